// File: doc/BRIEF.md
# Partitioned Word Store with Top-Address Select

This block is a synthesizable model of a static memory of 8,192 words of 24 bits. The low twelve address bits come straight from a port. The thirteenth (top) bit is picked by a one-bit multiplexer from one of two inputs, steered by a select pin. A host can tie the select pin to one of its own high address lines. Then a single array is split between two operand classes, for example vector data in the upper half and scalar or program data in the lower half, with no extra logic around it.

The device is selected only when both chip enables are asserted: one is active low, the other active high. Writes are captured on the rising clock edge. Reads are combinational, so the array can be built from registers. Address and enable changes reach the data output in the same cycle, and neither path adds latency over the other. Tristate pins are replaced by a data-out bus and a drive-enable flag. The data-out bus reads zero whenever it is not being driven. A standby flag shows when the chip is deselected. An active-low reset blocks writes while it is held; it does not clear the array.

Top module: `split_word_store`

## Requirements
- R1: On a rising clock edge where the chip is selected, reset is released and `wr_n` is 0, the 24-bit `din` is stored at the 13-bit word address. A later read of that address returns it.
- R2: The word address is `{top, lo_addr}`, where `top` is `hi_alt` when `hi_sel` is 1 and `hi_direct` when `hi_sel` is 0.
- R3: The chip is selected only when `en_n` is 0 and `en_p` is 1. In every other case, a clock edge with `wr_n` low leaves the array unchanged.
- R4: `standby` is 1 exactly when `en_n` is 1 or `en_p` is 0. While `standby` is 1, `dout_drive` is 0 and `dout` is zero.
- R5: When the chip is selected, `wr_n` is 1 and `oe_n` is 0, `dout_drive` is 1 and `dout` shows the addressed word in the same cycle. An address change is seen with no clock edge in between.
- R6: When `oe_n` is 1, `dout_drive` is 0 and `dout` is zero.
- R7: During a write (chip selected and `wr_n` 0), `dout_drive` is 0 and `dout` is zero, whatever the value of `oe_n`.
- R8: While `rst_n` is 0, no write reaches the array. Contents stored before reset are kept.
- R9: Two addresses with the same `lo_addr` but a different top bit hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| lo_addr | input | 12 | Low word-address bits |
| hi_direct | input | 1 | Top-bit source used when `hi_sel` is 0 |
| hi_alt | input | 1 | Top-bit source used when `hi_sel` is 1 |
| hi_sel | input | 1 | Picks the top-address source |
| en_n | input | 1 | Active-low chip enable |
| en_p | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| din | input | 24 | Write data |
| dout | output | 24 | Read data; zero when not driven |
| dout_drive | output | 1 | High when `dout` is actively driven |
| standby | output | 1 | High when the chip is deselected |

## Verification
The bench runs four kinds of corner case:
- **Top-bit multiplexer.** It swaps `hi_direct` and `hi_alt` with `hi_sel` held, and again with `hi_sel` flipped. A multiplexer with its select inverted, or a design that drops the top bit, returns the other half's word.
- **Write gating.** It tries writes with each chip enable deasserted on its own, and a write while reset is held. It then reads the word back, which exposes a design that ignores one enable or the reset.
- **Output gating.** It checks drive and data with `oe_n` low during a write and with `oe_n` high during a read. A design that drives during writes shows up here.
- **Read latency.** It changes the address twice within one clock period and expects new data each time. A registered read path lags by a cycle and fails this.

// File: rtl/sws_pkg.sv
package sws_pkg;
    localparam int LO_AW_DEF = 12;
    localparam int DW_DEF    = 24;

    typedef struct packed {
        logic sel;    // both chip enables asserted
        logic wr;     // write strobe for the coming edge
        logic rd;     // drive the data output
        logic sb;     // standby flag
    } ctl_t;
endpackage

// File: rtl/sws_top_mux.sv
module sws_top_mux #(
    parameter int LO_AW = sws_pkg::LO_AW_DEF,
    localparam int AW   = LO_AW + 1
) (
    input  logic [LO_AW-1:0] lo_addr,
    input  logic             hi_direct,
    input  logic             hi_alt,
    input  logic             hi_sel,
    output logic [AW-1:0]    word_addr
);
    typedef struct packed {
        logic             top;
        logic [LO_AW-1:0] low;
    } addr_t;

    addr_t addr_d;

    always_comb begin
        addr_d     = '0;
        addr_d.low = lo_addr;
        addr_d.top = hi_sel ? hi_alt : hi_direct;   // R2
    end

    assign word_addr = addr_d;
endmodule

// File: rtl/sws_ctl.sv
module sws_ctl
    import sws_pkg::*;
(
    input  logic rst_n,
    input  logic en_n,
    input  logic en_p,
    input  logic wr_n,
    input  logic oe_n,
    output ctl_t ctl
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d     = '0;
        ctl_d.sel = ~en_n & en_p;               // R3
        ctl_d.sb  = ~ctl_d.sel;                 // R4
        ctl_d.wr  = ctl_d.sel & ~wr_n & rst_n;  // R1, R8
        ctl_d.rd  = ctl_d.sel & wr_n & ~oe_n;   // R5, R6, R7
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/sws_array.sv
module sws_array #(
    parameter int LO_AW = sws_pkg::LO_AW_DEF,
    parameter int DW    = sws_pkg::DW_DEF,
    localparam int AW    = LO_AW + 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wreq_t;

    logic [DW-1:0] mem_q [DEPTH];
    wreq_t         wreq_d;

    always_comb begin
        wreq_d      = '0;
        wreq_d.en   = wr_en;
        wreq_d.addr = addr;
        wreq_d.data = wdata;
    end

    always_ff @(posedge clk) begin
        if (wreq_d.en) begin
            mem_q[wreq_d.addr] <= wreq_d.data;
        end
    end

    assign rdata = mem_q[addr];   // combinational read, no added cycle

    // R1: a strobed write is visible at its address after the edge
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(addr)] == $past(wdata)));

    // R3: without a strobe the addressed word keeps its value
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem_q[$past(addr)] === $past(rdata)));
endmodule

// File: rtl/split_word_store.sv
module split_word_store #(
    parameter int LO_AW = sws_pkg::LO_AW_DEF,
    parameter int DW    = sws_pkg::DW_DEF,
    localparam int AW   = LO_AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LO_AW-1:0] lo_addr,
    input  logic             hi_direct,
    input  logic             hi_alt,
    input  logic             hi_sel,
    input  logic             en_n,
    input  logic             en_p,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_drive,
    output logic             standby
);
    import sws_pkg::*;

    logic [AW-1:0] word_addr;
    logic [DW-1:0] rdata;
    ctl_t          ctl;

    sws_top_mux #(.LO_AW(LO_AW)) mux_i (
        .lo_addr   (lo_addr),
        .hi_direct (hi_direct),
        .hi_alt    (hi_alt),
        .hi_sel    (hi_sel),
        .word_addr (word_addr)
    );

    sws_ctl ctl_i (
        .rst_n (rst_n),
        .en_n  (en_n),
        .en_p  (en_p),
        .wr_n  (wr_n),
        .oe_n  (oe_n),
        .ctl   (ctl)
    );

    sws_array #(.LO_AW(LO_AW), .DW(DW)) array_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl.wr),
        .addr  (word_addr),
        .wdata (din),
        .rdata (rdata)
    );

    typedef struct packed {
        logic [DW-1:0] data;
        logic          drive;
        logic          sb;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d       = '0;
        out_d.drive = ctl.rd;
        out_d.sb    = ctl.sb;
        out_d.data  = ctl.rd ? rdata : '0;   // R6: undriven bus reads zero
    end

    assign dout       = out_d.data;
    assign dout_drive = out_d.drive;
    assign standby    = out_d.sb;

    // R4: deselected chip never drives
    p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!dout_drive && dout == '0));

    // R7: no drive during a selected write
    p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !standby) |-> !dout_drive);
endmodule

// File: tb/split_word_store_tb_top.sv
module split_word_store_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] lo_addr = '0;
    logic        hi_direct = 1'b0, hi_alt = 1'b0, hi_sel = 1'b0;
    logic        en_n = 1'b1, en_p = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic [23:0] din = '0;
    logic [23:0] dout;
    logic        dout_drive, standby;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [23:0] ref_mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    split_word_store dut_i (
        .clk(clk), .rst_n(rst_n), .lo_addr(lo_addr),
        .hi_direct(hi_direct), .hi_alt(hi_alt), .hi_sel(hi_sel),
        .en_n(en_n), .en_p(en_p), .wr_n(wr_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_drive(dout_drive), .standby(standby)
    );

    typedef struct packed {
        logic [11:0] lo;
        logic        hd, ha, sel, en_n, en_p, wr_n, oe_n;
        logic [23:0] din;
        logic        xdrv, xsb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{12'h005,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b0,1'b0, 24'hAAAAAA, 1'b0,1'b1, 4'd3}, // R3 en_n off
        '{12'h005,1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 24'hBBBBBB, 1'b0,1'b1, 4'd3}, // R3 en_p off
        '{12'h005,1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 24'h111111, 1'b0,1'b0, 4'd7}, // R7 write, oe low
        '{12'h005,1'b0,1'b1,1'b1, 1'b0,1'b1, 1'b0,1'b1, 24'h222222, 1'b0,1'b0, 4'd2}, // R2 top from alt
        '{12'h005,1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd9}, // R9 lower half
        '{12'h005,1'b0,1'b1,1'b1, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd9}, // R9 upper half
        '{12'h005,1'b1,1'b0,1'b1, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd2}, // R2 sel1 alt0
        '{12'h005,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd2}, // R2 sel0 direct1
        '{12'h005,1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b1, 24'h0,      1'b0,1'b0, 4'd6}, // R6 oe high
        '{12'hFFF,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b1, 24'hABCDEF, 1'b0,1'b0, 4'd1}, // R1 top word
        '{12'h000,1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b0,1'b1, 24'h000001, 1'b0,1'b0, 4'd1}, // R1 bottom word
        '{12'hFFF,1'b0,1'b1,1'b1, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd1}, // R1 read top
        '{12'h000,1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd1}, // R1 read bottom
        '{12'h005,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b0, 24'h0,      1'b0,1'b1, 4'd4}, // R4 read in standby
        '{12'h005,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0, 24'h999999, 1'b0,1'b1, 4'd3}, // R3 both off
        '{12'h005,1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd3}, // R3 word kept
        '{12'h005,1'b1,1'b1,1'b1, 1'b0,1'b1, 1'b1,1'b0, 24'h0,      1'b1,1'b0, 4'd5}  // R5 read upper
    };

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic drive_in(input logic [11:0] lo, input logic hd, input logic ha,
                            input logic sel, input logic en_n_v, input logic en_p_v,
                            input logic wr_n_v, input logic oe_n_v, input logic [23:0] d);
        lo_addr = lo; hi_direct = hd; hi_alt = ha; hi_sel = sel;
        en_n = en_n_v; en_p = en_p_v; wr_n = wr_n_v; oe_n = oe_n_v; din = d;
    endtask

    function automatic int waddr(input logic [11:0] lo, input logic top);
        return int'({top, lo});
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // reset state: deselected, in reset
        #1;
        chk(4, 32'(standby), 32'd1, "reset standby (R4)");
        chk(4, 32'(dout_drive), 32'd0, "reset drive (R4)");
        chk(6, 32'(dout), 32'd0, "reset dout");
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // table walk against associative reference
        for (int i = 0; i < NV; i++) begin
            logic top, sel_v, drv;
            int a;
            @(negedge clk);
            drive_in(VECS[i].lo, VECS[i].hd, VECS[i].ha, VECS[i].sel, VECS[i].en_n,
                     VECS[i].en_p, VECS[i].wr_n, VECS[i].oe_n, VECS[i].din);
            #1;
            top   = VECS[i].sel ? VECS[i].ha : VECS[i].hd;
            a     = waddr(VECS[i].lo, top);
            sel_v = !VECS[i].en_n && VECS[i].en_p;
            drv   = sel_v && VECS[i].wr_n && !VECS[i].oe_n;
            chk(int'(VECS[i].req), 32'(dout_drive), 32'(VECS[i].xdrv), $sformatf("vec %0d drive", i));
            chk(int'(VECS[i].req), 32'(standby), 32'(VECS[i].xsb), $sformatf("vec %0d standby", i));
            chk(int'(VECS[i].req), 32'(dout),
                (drv && ref_mem.exists(a)) ? 32'(ref_mem[a]) : 32'd0,
                $sformatf("vec %0d dout", i));
            if (sel_v && !VECS[i].wr_n) ref_mem[a] = VECS[i].din;
        end

        // R5: address changes seen within one cycle, no edge between
        @(negedge clk);
        drive_in(12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        #1 chk(5, 32'(dout), 32'hABCDEF, "same-cycle read top word (R5)");
        drive_in(12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        #1 chk(5, 32'(dout), 32'h000001, "same-cycle read after addr change (R5)");
        en_n = 1'b1;
        #1 chk(5, 32'(dout_drive), 32'd0, "same-cycle enable drop (R5)");

        // R8: write during reset is blocked
        @(negedge clk);
        drive_in(12'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 24'h654321);
        @(negedge clk);
        rst_n = 1'b0;
        drive_in(12'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 24'h123456);
        @(negedge clk);
        rst_n = 1'b1;
        drive_in(12'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        #1 chk(8, 32'(dout), 32'h654321, "word kept across reset write (R8)");

        // R7: write with oe low at another address, then read back
        @(negedge clk);
        drive_in(12'h7A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'h5A5A5A);
        #1 chk(7, 32'(dout), 32'd0, "dout zero during write (R7)");
        @(negedge clk);
        drive_in(12'h7A5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        #1 chk(1, 32'(dout), 32'h5A5A5A, "readback after write (R1)");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule